// File: doc/BRIEF.md
# Prioritized Trap Interrupt Arbiter

This block keeps a 64-bit pending vector for each of seven interrupt types and a one-bit-per-type summary word. Single-bit post and clear commands, each naming a type and a bit index, update the vectors on the next clock edge. A clear-all input empties every vector at once.

From the registered state, the block picks one interrupt to deliver. It uses a privilege flag and an enable flag for this, and the priority order depends on privilege. It reports the winner as a small code and, for the soft type, a level number. A separate read port returns the raw vector of any type. An any-pending flag tells the core that something is waiting, whatever the current mode.

Top module: `trap_irq_arbiter`

## Requirements
- R1: Types are encoded 0 trap-level-zero, 1 hypervisor tick match, 2 interrupt vector, 3 CPU mondo, 4 device mondo, 5 soft, 6 resumable error. A post of type t and index i (0..63) sets bit i of vector t and summary bit t at the next rising edge.
- R2: A clear of type t and index i clears bit i of vector t at the next edge. Summary bit t drops only once vector t is entirely zero.
- R3: Clear-all, or `rst_n` low at an edge, zeroes every vector and the summary word. Clear-all also overrides a post in the same cycle.
- R4: When a post and a clear name the same type and index in one cycle, the clear wins and the bit ends up zero.
- R5: With `hpriv`=1, `sel_code` is 0 unless `ie`=1. With `ie`=1, the order is tick match (code 2) and then interrupt vector (code 3); no other type is ever selected in this mode.
- R6: With `hpriv`=0, the order starts with trap-level-zero (code 1), then tick match (code 2), then interrupt vector (code 3). These three are selected whatever the value of `ie`.
- R7: With `hpriv`=0 and `ie`=1, the order continues after those three with CPU mondo (code 4), device mondo (code 5), soft (code 6) and resumable error (code 7). With `ie`=0, these four are never selected. Code 0 means nothing is selected.
- R8: The soft level is 14 when bit 0 or bit 16 of the soft vector is set. Otherwise it is the index of the highest set bit among bits 15..1, or 0 if none of those bits is set.
- R9: `sel_level` is 0 whenever `sel_code` is not 6.
- R10: `any_pend` is 1 exactly when the summary word is nonzero, whatever the values of `hpriv` and `ie`.
- R11: `rd_vec` shows the registered vector of type `rd_type` combinationally; `rd_type`=7 reads zero.
- R12: A post or a clear naming type 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_en | input | 1 | Post command valid |
| post_type | input | 3 | Type to post |
| post_idx | input | 6 | Bit index to post |
| clr_en | input | 1 | Clear command valid |
| clr_type | input | 3 | Type to clear |
| clr_idx | input | 6 | Bit index to clear |
| clr_all | input | 1 | Empty every vector |
| hpriv | input | 1 | Hypervisor-privileged mode |
| ie | input | 1 | Interrupt enable |
| rd_type | input | 3 | Type selected for the read port |
| rd_vec | output | 64 | Vector of `rd_type` |
| pend_summary | output | 7 | Summary word, one bit per type |
| any_pend | output | 1 | Any interrupt pending |
| sel_code | output | 3 | Selected interrupt code, 0 = none |
| sel_level | output | 4 | Soft level when `sel_code` is 6, else 0 |

## Verification
Three updates can land on the same cycle: a post and a clear of the same bit, a post and a clear of two different bits of one type, and a clear-all alongside a post. The bench drives each of these pairs in one cycle. It then judges the result through the read port and the summary after the next edge: the clear must win the shared bit, the other bit must survive, and clear-all must leave everything empty. Selection and update also meet, because a post changes `sel_code` only one edge later. The bench therefore samples the code at the negative edge after each update.

// File: rtl/tia_pkg.sv
// Shared encodings for the trap interrupt arbiter.
// Assumes exactly seven interrupt types; code = type + 1, code 0 = none.
package tia_pkg;
    localparam int NTYPES = 7;
    localparam int TYPE_W = 3;

    typedef enum logic [TYPE_W-1:0] {
        T_TLZERO = 3'd0,
        T_HTICK  = 3'd1,
        T_IVEC   = 3'd2,
        T_CPUMQ  = 3'd3,
        T_DEVMQ  = 3'd4,
        T_SOFT   = 3'd5,
        T_RESERR = 3'd6
    } irq_type_e;

    typedef enum logic [2:0] {
        C_NONE   = 3'd0,
        C_TLZERO = 3'd1,
        C_HTICK  = 3'd2,
        C_IVEC   = 3'd3,
        C_CPUMQ  = 3'd4,
        C_DEVMQ  = 3'd5,
        C_SOFT   = 3'd6,
        C_RESERR = 3'd7
    } irq_code_e;
endpackage

// File: rtl/tia_pending_bank.sv
// Pending-vector storage: one register per type plus its summary bit.
// Assumes single-bit post/clear per cycle; clear beats post; clear-all and
// reset beat both. Type numbers beyond NTYPES-1 match no register.
module tia_pending_bank
    import tia_pkg::*;
#(
    parameter int VEC_W = 64,
    localparam int IDX_W = $clog2(VEC_W)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          post_en,
    input  logic [TYPE_W-1:0]             post_type,
    input  logic [IDX_W-1:0]              post_idx,
    input  logic                          clr_en,
    input  logic [TYPE_W-1:0]             clr_type,
    input  logic [IDX_W-1:0]              clr_idx,
    input  logic                          clr_all,
    output logic [NTYPES-1:0][VEC_W-1:0]  pend_q,
    output logic [NTYPES-1:0]             summary_q
);
    for (genvar t = 0; t < NTYPES; t++) begin : g_type
        logic [VEC_W-1:0] set_m;
        logic [VEC_W-1:0] clr_m;
        logic [VEC_W-1:0] nxt;
        logic [VEC_W-1:0] vec_r;
        logic             sum_r;

        // decode this type's set and clear masks
        assign set_m = (post_en && post_type == TYPE_W'(t)) ? (VEC_W'(1) << post_idx) : '0;
        assign clr_m = (clr_en  && clr_type  == TYPE_W'(t)) ? (VEC_W'(1) << clr_idx)  : '0;
        assign nxt   = (vec_r | set_m) & ~clr_m;

        // register the vector and its summary bit
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) begin
                vec_r <= '0;
                sum_r <= 1'b0;
            end else begin
                vec_r <= nxt;
                sum_r <= |nxt;
            end
        end

        assign pend_q[t]    = vec_r;
        assign summary_q[t] = sum_r;
    end
endmodule

// File: rtl/tia_soft_level.sv
// Soft-interrupt level encoder.
// Bit 0 or bit 16 forces level 14; otherwise highest set bit in 15..1, else 0.
// Assumes VEC_W >= 17.
module tia_soft_level #(
    parameter int VEC_W = 64,
    parameter int LVL_W = 4
) (
    input  logic [VEC_W-1:0] soft_vec,
    output logic [LVL_W-1:0] level
);
    localparam int TOP_BIT   = (1 << LVL_W) - 1;
    localparam int FORCE_LVL = TOP_BIT - 1;
    localparam int ALIAS_BIT = TOP_BIT + 1;

    // priority-encode bits TOP_BIT..1, then apply the forced level
    always_comb begin
        level = '0;
        for (int b = 1; b <= TOP_BIT; b++) begin
            if (soft_vec[b]) level = LVL_W'(b);
        end
        if (soft_vec[0] || soft_vec[ALIAS_BIT]) level = LVL_W'(FORCE_LVL);
    end
endmodule

// File: rtl/tia_select.sv
// Mode-dependent priority selector working on the registered summary word.
// Privileged: only with enable, tick match then interrupt vector.
// Unprivileged: trap-level-zero, tick match, interrupt vector always;
// then mondos, soft, resumable error only with enable.
module tia_select
    import tia_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic [NTYPES-1:0] summary,
    input  logic              hpriv,
    input  logic              ie,
    input  logic [LVL_W-1:0]  soft_level,
    output logic [2:0]        code,
    output logic [LVL_W-1:0]  level
);
    irq_code_e win;

    // walk the order for the current mode and stop at the first pending type
    always_comb begin
        win = C_NONE;
        if (hpriv) begin
            if (ie) begin
                if      (summary[T_HTICK]) win = C_HTICK;
                else if (summary[T_IVEC])  win = C_IVEC;
            end
        end else begin
            if      (summary[T_TLZERO])      win = C_TLZERO;
            else if (summary[T_HTICK])       win = C_HTICK;
            else if (summary[T_IVEC])        win = C_IVEC;
            else if (ie) begin
                if      (summary[T_CPUMQ])   win = C_CPUMQ;
                else if (summary[T_DEVMQ])   win = C_DEVMQ;
                else if (summary[T_SOFT])    win = C_SOFT;
                else if (summary[T_RESERR])  win = C_RESERR;
            end
        end
    end

    assign code  = win;
    assign level = (win == C_SOFT) ? soft_level : '0;
endmodule

// File: rtl/trap_irq_arbiter.sv
// Top: pending storage, soft-level encoder, priority selector, read port.
// Assumes single-threaded use; outputs are combinational from registered state.
module trap_irq_arbiter
    import tia_pkg::*;
#(
    parameter int VEC_W = 64,
    localparam int IDX_W = $clog2(VEC_W),
    localparam int LVL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_en,
    input  logic [TYPE_W-1:0] post_type,
    input  logic [IDX_W-1:0]  post_idx,
    input  logic              clr_en,
    input  logic [TYPE_W-1:0] clr_type,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic              clr_all,
    input  logic              hpriv,
    input  logic              ie,
    input  logic [TYPE_W-1:0] rd_type,
    output logic [VEC_W-1:0]  rd_vec,
    output logic [NTYPES-1:0] pend_summary,
    output logic              any_pend,
    output logic [2:0]        sel_code,
    output logic [LVL_W-1:0]  sel_level
);
    logic [NTYPES-1:0][VEC_W-1:0] pend_q;
    logic [LVL_W-1:0]             soft_lvl;

    tia_pending_bank #(.VEC_W(VEC_W)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .post_en   (post_en),
        .post_type (post_type),
        .post_idx  (post_idx),
        .clr_en    (clr_en),
        .clr_type  (clr_type),
        .clr_idx   (clr_idx),
        .clr_all   (clr_all),
        .pend_q    (pend_q),
        .summary_q (pend_summary)
    );

    tia_soft_level #(.VEC_W(VEC_W), .LVL_W(LVL_W)) lvl_i (
        .soft_vec (pend_q[T_SOFT]),
        .level    (soft_lvl)
    );

    tia_select #(.LVL_W(LVL_W)) sel_i (
        .summary    (pend_summary),
        .hpriv      (hpriv),
        .ie         (ie),
        .soft_level (soft_lvl),
        .code       (sel_code),
        .level      (sel_level)
    );

    // read port mux; unmatched type numbers read zero
    always_comb begin
        rd_vec = '0;
        for (int t = 0; t < NTYPES; t++) begin
            if (rd_type == TYPE_W'(t)) rd_vec = pend_q[t];
        end
    end

    assign any_pend = |pend_summary;
endmodule

// File: rtl/tia_checker.sv
// Property checker for trap_irq_arbiter, attached by bind below.
module tia_checker
    import tia_pkg::*;
#(
    parameter int VEC_W = 64,
    localparam int IDX_W = $clog2(VEC_W)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         post_en,
    input logic [TYPE_W-1:0]            post_type,
    input logic [IDX_W-1:0]             post_idx,
    input logic                         clr_en,
    input logic [TYPE_W-1:0]            clr_type,
    input logic [IDX_W-1:0]             clr_idx,
    input logic                         clr_all,
    input logic                         hpriv,
    input logic                         ie,
    input logic [NTYPES-1:0][VEC_W-1:0] pend_q,
    input logic [NTYPES-1:0]            pend_summary,
    input logic                         any_pend,
    input logic [2:0]                   sel_code,
    input logic [3:0]                   sel_level
);
    // R1: a post that no clear touches lands in the vector and summary
    p_post_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (post_en && post_type < TYPE_W'(NTYPES) && !clr_all &&
         !(clr_en && clr_type == post_type && clr_idx == post_idx))
        |=> (pend_q[$past(post_type)][$past(post_idx)] && pend_summary[$past(post_type)]));

    // R2 and R4: a clear always leaves its bit at zero
    p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_type < TYPE_W'(NTYPES))
        |=> !pend_q[$past(clr_type)][$past(clr_idx)]);

    // R3: clear-all empties every vector
    p_clear_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (pend_q == '0 && pend_summary == '0));

    // R5: privileged without enable delivers nothing
    p_hpriv_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hpriv && !ie) |-> sel_code == 3'd0);

    // R5: privileged mode selects only tick match or interrupt vector
    p_hpriv_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hpriv |-> (sel_code == 3'd0 || sel_code == 3'd2 || sel_code == 3'd3));

    // R7: without enable the low four types are never chosen
    p_ie_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> sel_code <= 3'd3);

    // R9: level is zero unless soft wins
    p_level_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code != 3'd6) |-> sel_level == 4'd0);

    // R10: any-pending follows the summary word
    p_any_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        any_pend == (pend_summary != '0));

    // R2: each summary bit tracks whether its vector is nonzero
    for (genvar t = 0; t < NTYPES; t++) begin : g_sum
        p_summary_r2: assert property (@(posedge clk) disable iff (!rst_n)
            pend_summary[t] == (pend_q[t] != '0));
    end
endmodule

bind trap_irq_arbiter tia_checker #(.VEC_W(VEC_W)) chk_i (.*);

// File: tb/trap_irq_arbiter_tb_top.sv
module trap_irq_arbiter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_en = 1'b0;
    logic [2:0]  post_type = '0;
    logic [5:0]  post_idx = '0;
    logic        clr_en = 1'b0;
    logic [2:0]  clr_type = '0;
    logic [5:0]  clr_idx = '0;
    logic        clr_all = 1'b0;
    logic        hpriv = 1'b0;
    logic        ie = 1'b0;
    logic [2:0]  rd_type = '0;
    logic [63:0] rd_vec;
    logic [6:0]  pend_summary;
    logic        any_pend;
    logic [2:0]  sel_code;
    logic [3:0]  sel_level;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    trap_irq_arbiter dut_i (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_post(input int t, input int i);
        post_en = 1'b1; post_type = 3'(t); post_idx = 6'(i);
        @(negedge clk);
        post_en = 1'b0;
    endtask

    task automatic do_clr(input int t, input int i);
        clr_en = 1'b1; clr_type = 3'(t); clr_idx = 6'(i);
        @(negedge clk);
        clr_en = 1'b0;
    endtask

    task automatic do_clr_all();
        clr_all = 1'b1;
        @(negedge clk);
        clr_all = 1'b0;
    endtask

    function automatic logic [2:0] exp_code(input logic [6:0] m, input logic hp, input logic en);
        if (hp) begin
            if (!en) return 3'd0;
            if (m[1]) return 3'd2;
            if (m[2]) return 3'd3;
            return 3'd0;
        end
        for (int t = 0; t < 3; t++) if (m[t]) return 3'(t + 1);
        if (en) for (int t = 3; t < 7; t++) if (m[t]) return 3'(t + 1);
        return 3'd0;
    endfunction

    function automatic logic [3:0] exp_level(input logic [63:0] v);
        if (v[0] || v[16]) return 4'd14;
        for (int b = 15; b >= 1; b--) if (v[b]) return 4'(b);
        return 4'd0;
    endfunction

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset state
        chk("R3 reset any_pend", 64'(any_pend), 64'd0);
        chk("R3 reset code", 64'(sel_code), 64'd0);
        for (int t = 0; t < 8; t++) begin
            rd_type = 3'(t); #1;
            chk("R3 reset rd_vec", rd_vec, 64'd0);
        end

        // R1 R2 R7 R8 R11: every type and index, single bit
        hpriv = 1'b0; ie = 1'b1;
        for (int t = 0; t < 7; t++) begin
            for (int i = 0; i < 64; i++) begin
                do_post(t, i);
                rd_type = 3'(t); #1;
                chk("R1 post rd_vec", rd_vec, 64'd1 << i);
                chk("R1 post summary", 64'(pend_summary), 64'd1 << t);
                chk("R7 single code", 64'(sel_code), 64'(t + 1));
                if (t == 5) chk("R8 single level", 64'(sel_level), 64'(exp_level(64'd1 << i)));
                else chk("R9 level zero", 64'(sel_level), 64'd0);
                do_clr(t, i);
                chk("R2 clear rd_vec", rd_vec, 64'd0);
                chk("R2 clear any_pend", 64'(any_pend), 64'd0);
            end
        end

        // R5 R6 R7 R9 R10: every pending mask under all four modes
        for (int m = 0; m < 128; m++) begin
            do_clr_all();
            for (int t = 0; t < 7; t++) if (m[t]) do_post(t, 3);
            for (int md = 0; md < 4; md++) begin
                hpriv = md[1]; ie = md[0]; #1;
                chk(hpriv ? "R5 hpriv code" : (ie ? "R7 order code" : "R6 order code"),
                    64'(sel_code), 64'(exp_code(7'(m), hpriv, ie)));
                chk("R9 level", 64'(sel_level),
                    (exp_code(7'(m), hpriv, ie) == 3'd6) ? 64'd3 : 64'd0);
                chk("R10 any_pend", 64'(any_pend), 64'(m != 0));
            end
        end

        // R8: soft vector pairs across bits 0..20
        hpriv = 1'b0; ie = 1'b1; rd_type = 3'd5;
        for (int j = 0; j < 21; j++) begin
            for (int k = j; k < 21; k++) begin
                do_clr_all();
                do_post(5, j);
                do_post(5, k);
                chk("R8 pair level", 64'(sel_level), 64'(exp_level((64'd1 << j) | (64'd1 << k))));
            end
        end

        // R2: two bits, clear one at a time; summary holds until empty
        do_clr_all();
        do_post(4, 10);
        do_post(4, 40);
        do_clr(4, 10);
        rd_type = 3'd4; #1;
        chk("R2 partial summary", 64'(pend_summary[4]), 64'd1);
        chk("R2 partial rd_vec", rd_vec, 64'd1 << 40);
        do_clr(4, 40);
        chk("R2 empty summary", 64'(pend_summary[4]), 64'd0);

        // R4: same-bit post and clear in one cycle, from set and from clear
        do_post(2, 7);
        post_en = 1'b1; post_type = 3'd2; post_idx = 6'd7;
        clr_en = 1'b1; clr_type = 3'd2; clr_idx = 6'd7;
        @(negedge clk);
        post_en = 1'b0; clr_en = 1'b0;
        rd_type = 3'd2; #1;
        chk("R4 clear wins set bit", rd_vec, 64'd0);
        post_en = 1'b1; post_type = 3'd2; post_idx = 6'd9;
        clr_en = 1'b1; clr_type = 3'd2; clr_idx = 6'd9;
        @(negedge clk);
        post_en = 1'b0; clr_en = 1'b0; #1;
        chk("R4 clear wins fresh bit", rd_vec, 64'd0);
        chk("R4 summary", 64'(pend_summary), 64'd0);

        // R2: post and clear of different bits of one type in one cycle
        do_post(6, 1);
        post_en = 1'b1; post_type = 3'd6; post_idx = 6'd2;
        clr_en = 1'b1; clr_type = 3'd6; clr_idx = 6'd1;
        @(negedge clk);
        post_en = 1'b0; clr_en = 1'b0;
        rd_type = 3'd6; #1;
        chk("R2 mixed same cycle", rd_vec, 64'd4);

        // R3: clear-all with a post in the same cycle
        post_en = 1'b1; post_type = 3'd0; post_idx = 6'd5;
        clr_all = 1'b1;
        @(negedge clk);
        post_en = 1'b0; clr_all = 1'b0; #1;
        chk("R3 clear-all beats post", 64'(pend_summary), 64'd0);

        // R12: type 7 post and clear are ignored
        do_post(7, 0);
        chk("R12 post type 7", 64'(pend_summary), 64'd0);
        do_post(1, 0);
        do_clr(7, 0);
        rd_type = 3'd1; #1;
        chk("R12 clear type 7", rd_vec, 64'd1);

        // R11: out-of-range read is zero while state is nonzero
        rd_type = 3'd7; #1;
        chk("R11 type 7 read", rd_vec, 64'd0);

        // R3: reset clears live state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; #1;
        chk("R3 reset clears", 64'(any_pend), 64'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule